// File: doc/BRIEF.md
# Reference-count header update unit

This block computes the header side of a counted pointer store. When software replaces the pointer held in one memory word, the object it used to point at (the old reference) loses one count, and the object now pointed at (the new reference) gains one. The surrounding datapath reads the 16-bit header word that sits two words below each reference. It presents both references and both header words with a single strobe. One cycle later it receives the rewritten headers, a write enable for each one, a request to enqueue the old object in the zero-count table, and a trap code if a rule was broken.

The header word is numbered with bit 15 as the most significant bit:

| Bits | Field |
|------|-------|
| 15 | in-table flag |
| 14 | may-be-on-stack flag |
| 13:8 | size class |
| 7 | finalize flag |
| 6:1 | 6-bit reference count |
| 0 | sticky count-overflowed flag |

Because the count's least significant bit is bit 1, one count step adds or subtracts 2 from the whole word. A global collection-in-progress input supplies the value that a decremented header takes for its may-be-on-stack flag.

The unit works only on header bits. Fetching and storing the headers, keeping the table write pointer and writing the pointer itself are done elsewhere.

Top module: `rch_update`

## Requirements
- R1: For a non-null new reference that differs from the old one, the new header output is the input plus 2 with bit 14 cleared, and `new_wr` is 1.
- R2: For a non-null old reference that differs from the new one, with a count of 2 or more, the old header output is the input minus 2 with bit 14 set equal to `collecting`. `old_wr` is 1 and `enq` is 0.
- R3: When `old_ref` equals `new_ref`, both header outputs equal their inputs, both write enables are 0, `enq` is 0 and `trap_code` is 0, whatever the header contents.
- R4: A reference equal to zero leaves its header unchanged, with its write enable at 0. Its count is never examined for a trap.
- R5: If the new header's count is 63, `trap_code` is 1.
- R6: Decrementing a count of 0 whose bit 0 is 0 gives `trap_code` 5.
- R7: Decrementing a count of 0 whose bit 0 is 1 gives `trap_code` 3.
- R8: A count going from 1 to 0 with bit 0 set writes the decremented header with bit 15 unchanged, and `enq` is 0.
- R9: A count going from 1 to 0 with bit 0 clear and bit 15 clear also sets bit 15 in the old header output and raises `enq`.
- R10: A count going from 1 to 0 with bit 0 clear and bit 15 already set leaves bit 15 set, and `enq` is 0.
- R11: Whenever `trap_code` is nonzero, both header outputs equal their inputs, and `old_wr`, `new_wr` and `enq` are 0.
- R12: Results are registered. `done` is high exactly in the cycle after each cycle with `in_valid` high, and otherwise low. Strobes on consecutive cycles give consecutive results.
- R13: When the new header would overflow and the old header would also trap, `trap_code` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| in_valid | input | 1 | strobe; both references and headers are valid |
| collecting | input | 1 | collection-in-progress flag |
| old_ref | input | REF_W | reference being overwritten |
| new_ref | input | REF_W | reference being stored |
| old_hdr | input | 16 | header word of the old object |
| new_hdr | input | 16 | header word of the new object |
| done | output | 1 | result valid pulse |
| old_hdr_o | output | 16 | rewritten old header |
| old_wr | output | 1 | old header must be written back |
| new_hdr_o | output | 16 | rewritten new header |
| new_wr | output | 1 | new header must be written back |
| enq | output | 1 | enqueue old object in zero-count table |
| trap_code | output | 3 | 0 none, 1 overflow, 3 underflow, 5 bug |

## Verification
The bench drives the transitions at the edges of the count range:

- **Count 63 on the new object.** A design that wraps the count would silently corrupt it instead of trapping. The boundary below it, an increment from 62 to 63, must not trap.
- **Count 0 on the old object, with and without overflow.** A design that swaps the two trap codes, or that leaves a partial write behind a trap, is caught here.
- **The three 1-to-0 cases.** A design that tests overflow in the wrong place, or that re-enqueues an object already in the table, would show a wrong `enq` or a wrong bit 15.
- **Equal references, null references and combined traps.** With equal references, null references or both objects trapping at once, a missing guard or the wrong trap priority shows up as an unexpected write or trap code.

// File: rtl/rch_pkg.sv
package rch_pkg;
   localparam int HDR_W   = 16;
   localparam int CNT_W   = 6;
   localparam int CNT_LSB = 1;
   localparam int OVF_BIT = 0;
   localparam int MOS_BIT = 14;
   localparam int INT_BIT = 15;
   localparam logic [HDR_W-1:0] CNT_STEP = HDR_W'(1) << CNT_LSB;
   localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

   typedef enum logic [2:0] {
      TRAP_NONE  = 3'd0,
      TRAP_OVF   = 3'd1,
      TRAP_UNDER = 3'd3,
      TRAP_BUG   = 3'd5
   } trap_e;

   typedef struct packed {
      logic [HDR_W-1:0] hdr;
      logic             wr;
      logic             enq;
      trap_e            trap;
   } side_res_t;
endpackage

// File: rtl/rch_dec.sv
module rch_dec
   import rch_pkg::*;
(
   input  logic             active,
   input  logic             collecting,
   input  logic [HDR_W-1:0] hdr,
   output side_res_t        res
);
   logic [CNT_W-1:0] cnt;
   logic             ovf;

   assign cnt = hdr[CNT_LSB +: CNT_W];
   assign ovf = hdr[OVF_BIT];

   always_comb begin
      res      = '0;
      res.hdr  = hdr;
      res.trap = TRAP_NONE;
      if (active) begin
         if (cnt == '0) begin
            res.trap = ovf ? TRAP_UNDER : TRAP_BUG;
         end else begin
            res.hdr          = hdr - CNT_STEP;
            res.hdr[MOS_BIT] = collecting;
            res.wr           = 1'b1;
            if (cnt == CNT_W'(1) && !ovf && !hdr[INT_BIT]) begin
               res.hdr[INT_BIT] = 1'b1;
               res.enq          = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rch_inc.sv
module rch_inc
   import rch_pkg::*;
(
   input  logic             active,
   input  logic [HDR_W-1:0] hdr,
   output side_res_t        res
);
   logic [CNT_W-1:0] cnt;

   assign cnt = hdr[CNT_LSB +: CNT_W];

   always_comb begin
      res      = '0;
      res.hdr  = hdr;
      res.trap = TRAP_NONE;
      if (active) begin
         if (cnt == CNT_MAX) begin
            res.trap = TRAP_OVF;
         end else begin
            res.hdr          = hdr + CNT_STEP;
            res.hdr[MOS_BIT] = 1'b0;
            res.wr           = 1'b1;
         end
      end
   end
endmodule

// File: rtl/rch_update.sv
module rch_update
   import rch_pkg::*;
#(
   parameter int REF_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             collecting,
   input  logic [REF_W-1:0] old_ref,
   input  logic [REF_W-1:0] new_ref,
   input  logic [HDR_W-1:0] old_hdr,
   input  logic [HDR_W-1:0] new_hdr,
   output logic             done,
   output logic [HDR_W-1:0] old_hdr_o,
   output logic             old_wr,
   output logic [HDR_W-1:0] new_hdr_o,
   output logic             new_wr,
   output logic             enq,
   output logic [2:0]       trap_code
);
   generate
      if (REF_W < 2) begin : g_bad_width
         $error("rch_update: REF_W must be at least 2");
      end
   endgenerate

   logic      same_ref, old_act, new_act, any_trap;
   side_res_t dec_r, inc_r;
   trap_e     trap_sel;

   assign same_ref = (old_ref == new_ref);
   assign old_act  = !same_ref && (old_ref != '0);
   assign new_act  = !same_ref && (new_ref != '0);

   rch_dec u_dec (
      .active     (old_act),
      .collecting (collecting),
      .hdr        (old_hdr),
      .res        (dec_r)
   );

   rch_inc u_inc (
      .active (new_act),
      .hdr    (new_hdr),
      .res    (inc_r)
   );

   // new-side overflow wins over old-side faults
   always_comb begin
      if (inc_r.trap != TRAP_NONE) trap_sel = inc_r.trap;
      else                         trap_sel = dec_r.trap;
   end
   assign any_trap = (trap_sel != TRAP_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done      <= 1'b0;
         old_hdr_o <= '0;
         old_wr    <= 1'b0;
         new_hdr_o <= '0;
         new_wr    <= 1'b0;
         enq       <= 1'b0;
         trap_code <= '0;
      end else begin
         done <= in_valid;
         if (in_valid) begin
            trap_code <= trap_sel;
            if (any_trap) begin
               old_hdr_o <= old_hdr;
               new_hdr_o <= new_hdr;
               old_wr    <= 1'b0;
               new_wr    <= 1'b0;
               enq       <= 1'b0;
            end else begin
               old_hdr_o <= dec_r.hdr;
               new_hdr_o <= inc_r.hdr;
               old_wr    <= dec_r.wr;
               new_wr    <= inc_r.wr;
               enq       <= dec_r.enq;
            end
         end
      end
   end
endmodule

// File: rtl/rch_checker.sv
module rch_checker
   import rch_pkg::*;
#(
   parameter int REF_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [REF_W-1:0] old_ref,
   input logic [REF_W-1:0] new_ref,
   input logic [HDR_W-1:0] old_hdr,
   input logic [HDR_W-1:0] new_hdr,
   input logic             done,
   input logic [HDR_W-1:0] old_hdr_o,
   input logic             old_wr,
   input logic [HDR_W-1:0] new_hdr_o,
   input logic             new_wr,
   input logic             enq,
   input logic [2:0]       trap_code
);
   assert_done_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> done);

   assert_done_needs_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !done);

   assert_trap_blocks_writes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && trap_code != 3'd0) |-> (!old_wr && !new_wr && !enq));

   assert_same_ref_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && old_ref == new_ref) |=>
         (!old_wr && !new_wr && !enq && trap_code == 3'd0 &&
          old_hdr_o == $past(old_hdr) && new_hdr_o == $past(new_hdr)));

   assert_null_old_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && old_ref == '0) |=> !old_wr);

   assert_enq_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && enq) |-> (old_wr && old_hdr_o[INT_BIT] && !$past(old_hdr[INT_BIT])));

   assert_inc_clears_stack_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && new_wr) |-> !new_hdr_o[MOS_BIT]);

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && old_ref != new_ref && new_ref != '0 && new_hdr[6:1] == 6'd63)
         |=> (trap_code == 3'd1));

   assert_code_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (trap_code == 3'd0 || trap_code == 3'd1 ||
                trap_code == 3'd3 || trap_code == 3'd5));
endmodule

bind rch_update rch_checker #(.REF_W(REF_W)) u_rch_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .old_ref   (old_ref),
   .new_ref   (new_ref),
   .old_hdr   (old_hdr),
   .new_hdr   (new_hdr),
   .done      (done),
   .old_hdr_o (old_hdr_o),
   .old_wr    (old_wr),
   .new_hdr_o (new_hdr_o),
   .new_wr    (new_wr),
   .enq       (enq),
   .trap_code (trap_code)
);

// File: tb/rch_update_test.sv
`timescale 1ns/1ps
module rch_update_test;
   localparam int REF_W = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic             collecting = 1'b0;
   logic [REF_W-1:0] old_ref = '0;
   logic [REF_W-1:0] new_ref = '0;
   logic [15:0]      old_hdr = '0;
   logic [15:0]      new_hdr = '0;
   logic             done;
   logic [15:0]      old_hdr_o;
   logic             old_wr;
   logic [15:0]      new_hdr_o;
   logic             new_wr;
   logic             enq;
   logic [2:0]       trap_code;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   typedef struct {
      logic [15:0] oh;
      logic        ow;
      logic [15:0] nh;
      logic        nw;
      logic        eq;
      logic [2:0]  tc;
      string       tag;
   } exp_t;

   exp_t expq[$];

   rch_update #(.REF_W(REF_W)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .collecting(collecting),
      .old_ref(old_ref), .new_ref(new_ref), .old_hdr(old_hdr), .new_hdr(new_hdr),
      .done(done), .old_hdr_o(old_hdr_o), .old_wr(old_wr), .new_hdr_o(new_hdr_o),
      .new_wr(new_wr), .enq(enq), .trap_code(trap_code)
   );

   always #2.5 clk = ~clk;

   function automatic logic [15:0] mk(input logic it, input logic ms, input logic [5:0] sz,
                                      input logic fin, input logic [5:0] cnt, input logic ov);
      return {it, ms, sz, fin, cnt, ov};
   endfunction

   task automatic send(input logic [REF_W-1:0] oref, input logic [REF_W-1:0] nref,
                       input logic [15:0] oh, input logic [15:0] nh, input logic coll,
                       input logic [15:0] e_oh, input logic e_ow,
                       input logic [15:0] e_nh, input logic e_nw,
                       input logic e_eq, input logic [2:0] e_tc, input string tag);
      exp_t e;
      @(negedge clk);
      old_ref = oref; new_ref = nref; old_hdr = oh; new_hdr = nh;
      collecting = coll; in_valid = 1'b1;
      e.oh = e_oh; e.ow = e_ow; e.nh = e_nh; e.nw = e_nw;
      e.eq = e_eq; e.tc = e_tc; e.tag = tag;
      expq.push_back(e);
   endtask

   // monitor: compare each result against the oldest pending expectation
   always @(negedge clk) begin
      if (rst_n && done) begin
         checks++;
         if (expq.size() == 0) begin
            fails++;
            $display("FAIL R12 unexpected done: actual 1 expected 0");
         end else begin
            exp_t e;
            e = expq.pop_front();
            if (old_hdr_o !== e.oh || old_wr !== e.ow || new_hdr_o !== e.nh ||
                new_wr !== e.nw || enq !== e.eq || trap_code !== e.tc) begin
               fails++;
               $display("FAIL %s: actual oh=%h ow=%b nh=%h nw=%b enq=%b trap=%0d expected oh=%h ow=%b nh=%h nw=%b enq=%b trap=%0d",
                        e.tag, old_hdr_o, old_wr, new_hdr_o, new_wr, enq, trap_code,
                        e.oh, e.ow, e.nh, e.nw, e.eq, e.tc);
            end
         end
      end
   end

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 20000);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] h0, h1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (done !== 1'b0 || old_wr !== 1'b0 || new_wr !== 1'b0 || enq !== 1'b0 || trap_code !== 3'd0) begin
         fails++;
         $display("FAIL R12 reset: actual done=%b ow=%b nw=%b enq=%b trap=%0d expected all 0",
                  done, old_wr, new_wr, enq, trap_code);
      end

      // R1 R2: plain decrement and increment, collecting set
      send(32'h100, 32'h200, mk(0,0,5,0,3,0), mk(0,1,7,1,10,0), 1'b1,
           mk(0,1,5,0,2,0), 1, mk(0,0,7,1,11,0), 1, 0, 0, "R1 R2 basic collecting");
      // R2: collecting clear drops may-be-on-stack, overflow kept
      send(32'h104, 32'h208, mk(0,1,9,0,5,1), mk(0,0,1,0,0,0), 1'b0,
           mk(0,0,9,0,4,1), 1, mk(0,0,1,0,1,0), 1, 0, 0, "R2 idle decrement");
      // R3: equal references, headers that would otherwise trap
      h0 = mk(0,0,1,0,0,0); h1 = mk(1,1,2,0,63,0);
      send(32'h300, 32'h300, h0, h1, 1'b1, h0, 0, h1, 0, 0, 0, "R3 same ref");
      // R4: null old reference, count 0 not examined
      h0 = mk(0,1,2,0,0,0);
      send(32'h0, 32'h400, h0, mk(0,1,3,0,62,1), 1'b0,
           h0, 0, mk(0,0,3,0,63,1), 0 | 1, 0, 0, "R4 null old, R1 62 to 63");
      // R4: null new reference, count 63 not examined
      h1 = mk(0,0,4,0,63,0);
      send(32'h500, 32'h0, mk(0,0,4,1,2,0), h1, 1'b1,
           mk(0,1,4,1,1,0), 1, h1, 0, 0, 0, "R4 null new");
      // R5 R11: new overflow
      h0 = mk(0,0,6,0,4,0); h1 = mk(0,1,6,0,63,0);
      send(32'h600, 32'h604, h0, h1, 1'b0, h0, 0, h1, 0, 0, 1, "R5 R11 overflow");
      // R6: bug trap
      h0 = mk(0,0,7,0,0,0); h1 = mk(0,0,7,0,1,0);
      send(32'h700, 32'h704, h0, h1, 1'b1, h0, 0, h1, 0, 0, 5, "R6 zero no-ovf");
      // R7: underflow trap
      h0 = mk(0,1,8,0,0,1);
      send(32'h800, 32'h804, h0, h1, 1'b0, h0, 0, h1, 0, 0, 3, "R7 zero ovf");
      // R8: 1 to 0 after overflow
      send(32'h900, 32'h904, mk(0,0,9,0,1,1), mk(0,0,9,0,5,0), 1'b1,
           mk(0,1,9,0,0,1), 1, mk(0,0,9,0,6,0), 1, 0, 0, "R8 1to0 ovf");
      // R9: 1 to 0, not in table
      send(32'hA00, 32'hA04, mk(0,0,10,1,1,0), mk(0,0,10,0,0,0), 1'b0,
           mk(1,0,10,1,0,0), 1, mk(0,0,10,0,1,0), 1, 1, 0, "R9 enqueue");
      // R10: 1 to 0, already in table
      send(32'hB00, 32'hB04, mk(1,0,11,0,1,0), mk(0,0,11,0,0,0), 1'b1,
           mk(1,1,11,0,0,0), 1, mk(0,0,11,0,1,0), 1, 0, 0, "R10 already in table");
      // R13: both sides trap, overflow code wins
      h0 = mk(0,0,12,0,0,0); h1 = mk(0,0,12,0,63,0);
      send(32'hC00, 32'hC04, h0, h1, 1'b0, h0, 0, h1, 0, 0, 1, "R13 priority");
      // R4: both null (equal too), nothing happens
      h0 = mk(0,0,13,0,0,1); h1 = mk(0,0,13,0,63,0);
      send(32'h0, 32'h0, h0, h1, 1'b1, h0, 0, h1, 0, 0, 0, "R4 both null");
      // R2: count 63 decrement, R1 from 0
      send(32'hD00, 32'hD04, mk(0,0,14,0,63,1), mk(1,1,14,1,0,1), 1'b1,
           mk(0,1,14,0,62,1), 1, mk(1,0,14,1,1,1), 1, 0, 0, "R2 R1 range ends");
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      checks++;
      if (done !== 1'b0 || expq.size() != 0) begin
         fails++;
         $display("FAIL R12 idle: actual done=%b pending=%0d expected done=0 pending=0",
                  done, expq.size());
      end
      finish_run();
   end
endmodule